// File: doc/BRIEF.md
# Display controller command sequencer

This block produces the configuration byte streams for a monochrome graphic LCD controller. The controller sits behind a serial byte link. The block runs four fixed scripts: a power-on initialization, an entry into sleep, a wake-up, and a contrast change. A single-cycle request pulse starts each script. Bytes leave the block one at a time through a valid/ready handshake to a downstream serial shifter. Each byte carries a command/data select flag.

While a script runs, `busy` is high and any new request is dropped. A one-cycle `done` pulse marks the acceptance of the final byte. The contrast level comes from a runtime input and is clamped to six bits. It is kept in a register so that a later initialization replays it. Until a contrast change is taken, that register holds 33.

Top module: `lcd_cmd_seq`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are low.
- R2: Every byte presented with `out_valid` high has `out_dc` low, which is the command encoding (high would mean data).
- R3: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high and the same `out_byte`. The next byte follows only after a transfer where both are high.
- R4: Initialization emits these eleven bytes: E2, A2, A0, C8, A4, 40, 25, 81, the stored level, 2F, AF. With no contrast change since reset, the stored level is 33 (0x21).
- R5: A contrast change emits 81 and then the level. The level is `contrast_in` when that value is 63 or less, and 63 (0x3F) otherwise.
- R6: The clamped level of the last accepted contrast change becomes the stored level used by later initializations.
- R7: Sleep entry emits AC, 00, AE, A5.
- R8: Wake-up emits A4, AD, 00, AF.
- R9: A request that arrives while `busy` is high is ignored. No extra bytes follow the running script.
- R10: When requests arrive together, initialization wins over sleep, sleep wins over wake-up, and wake-up wins over contrast.
- R11: `done` is high for exactly one cycle, in the cycle after the last byte's transfer. In that cycle `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_init | input | 1 | Start the initialization script |
| req_sleep | input | 1 | Start the sleep-entry script |
| req_wake | input | 1 | Start the wake-up script |
| req_contrast | input | 1 | Start the contrast script |
| contrast_in | input | 8 | Requested contrast level, sampled with `req_contrast` |
| out_byte | output | 8 | Byte offered to the serial shifter |
| out_dc | output | 1 | Command/data select (0 = command) |
| out_valid | output | 1 | `out_byte` is valid |
| out_ready | input | 1 | Shifter accepts the byte this cycle |
| busy | output | 1 | A script is running |
| done | output | 1 | One-cycle pulse after the last byte is taken |

## Verification
The assertions assume the shifter may hold `out_ready` low for any number of cycles but never drops a byte it has taken. They also assume request pulses last one cycle and that `contrast_in` is stable in the cycle a contrast request is raised. The bench drives requests only on falling edges for exactly one cycle. It holds `out_ready` either steadily high or low for a few cycles and then high, so every transfer follows a byte that has been held stable. Overlapping requests are applied on purpose, both together and during a running script, so the priority and drop rules are exercised.

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq #(
  parameter int          IN_W        = 8,
  parameter int          LVL_W       = 6,
  parameter int          LVL_DEFAULT = 33
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_init,
  input  logic            req_sleep,
  input  logic            req_wake,
  input  logic            req_contrast,
  input  logic [IN_W-1:0] contrast_in,
  output logic [7:0]      out_byte,
  output logic            out_dc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            busy,
  output logic            done
);
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  typedef enum logic [1:0] {OP_INIT, OP_SLEEP, OP_WAKE, OP_CON} op_t;

  op_t              op_q;
  logic [3:0]       idx_q;
  logic [3:0]       last_idx;
  logic             busy_q, done_q;
  logic [LVL_W-1:0] lvl_q, lvl_new;
  logic [7:0]       lvl_byte;
  logic             any_req, xfer, at_last;

  assign any_req   = req_init | req_sleep | req_wake | req_contrast;
  assign lvl_new   = (int'(contrast_in) > LVL_MAX) ? LVL_W'(LVL_MAX) : contrast_in[LVL_W-1:0];
  assign lvl_byte  = 8'(lvl_q);
  assign xfer      = busy_q & out_ready;
  assign at_last   = (idx_q == last_idx);
  assign busy      = busy_q;
  assign out_valid = busy_q;
  assign out_dc    = 1'b0;
  assign done      = done_q;

  always_comb begin
    case (op_q)
      OP_INIT:  last_idx = 4'd10;
      OP_SLEEP: last_idx = 4'd3;
      OP_WAKE:  last_idx = 4'd3;
      default:  last_idx = 4'd1;
    endcase
  end

  always_comb begin
    out_byte = 8'h00;
    case (op_q)
      OP_INIT:
        case (idx_q)
          4'd0:    out_byte = 8'hE2;
          4'd1:    out_byte = 8'hA2;
          4'd2:    out_byte = 8'hA0;
          4'd3:    out_byte = 8'hC8;
          4'd4:    out_byte = 8'hA4;
          4'd5:    out_byte = 8'h40;
          4'd6:    out_byte = 8'h25;
          4'd7:    out_byte = 8'h81;
          4'd8:    out_byte = lvl_byte;
          4'd9:    out_byte = 8'h2F;
          default: out_byte = 8'hAF;
        endcase
      OP_SLEEP:
        case (idx_q)
          4'd0:    out_byte = 8'hAC;
          4'd1:    out_byte = 8'h00;
          4'd2:    out_byte = 8'hAE;
          default: out_byte = 8'hA5;
        endcase
      OP_WAKE:
        case (idx_q)
          4'd0:    out_byte = 8'hA4;
          4'd1:    out_byte = 8'hAD;
          4'd2:    out_byte = 8'h00;
          default: out_byte = 8'hAF;
        endcase
      default:
        out_byte = (idx_q == 4'd0) ? 8'h81 : lvl_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_INIT;
      idx_q  <= 4'd0;
      lvl_q  <= LVL_W'(LVL_DEFAULT);
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (xfer) begin
          if (at_last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 4'd1;
          end
        end
      end else if (any_req) begin
        busy_q <= 1'b1;
        idx_q  <= 4'd0;
        if (req_init)       op_q <= OP_INIT;
        else if (req_sleep) op_q <= OP_SLEEP;
        else if (req_wake)  op_q <= OP_WAKE;
        else begin
          op_q  <= OP_CON;
          lvl_q <= lvl_new;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_cmd_seq_chk.sv
module lcd_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] out_byte,
  input logic       out_dc,
  input logic       out_valid,
  input logic       out_ready,
  input logic       busy,
  input logic       done
);
  a_r2_cmd_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_dc);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  a_r5_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_byte == 8'h81) |=> (out_valid && out_byte <= 8'd63));

  a_r11_done_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(out_valid && out_ready)));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (out_byte == 8'hE2 || out_byte == 8'hAC ||
                     out_byte == 8'hA4 || out_byte == 8'h81));
endmodule

bind lcd_cmd_seq lcd_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_byte(out_byte), .out_dc(out_dc),
  .out_valid(out_valid), .out_ready(out_ready), .busy(busy), .done(done)
);

// File: tb/lcd_cmd_seq_bench.sv
`timescale 1ns/1ps
module lcd_cmd_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_init = 0, req_sleep = 0, req_wake = 0, req_contrast = 0;
  logic [7:0] contrast_in = 8'd0;
  logic [7:0] out_byte;
  logic       out_dc, out_valid, busy, done;
  logic       out_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  int dc_bad = 0;
  int cap_n = 0;
  logic [7:0] cap [0:31];
  bit finished = 0;

  always #2.5 clk = ~clk;

  lcd_cmd_seq u_lcd_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_init(req_init), .req_sleep(req_sleep),
    .req_wake(req_wake), .req_contrast(req_contrast), .contrast_in(contrast_in),
    .out_byte(out_byte), .out_dc(out_dc), .out_valid(out_valid),
    .out_ready(out_ready), .busy(busy), .done(done)
  );

  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      if (cap_n < 32) cap[cap_n] = out_byte;
      cap_n = cap_n + 1;
    end
    if (out_valid && out_dc) dc_bad = dc_bad + 1;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(int op);
    case (op)
      0: return 11;
      1: return 4;
      2: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic logic [7:0] exp_byte(int op, int i, logic [7:0] lvl);
    logic [7:0] ini [0:10];
    logic [7:0] slp [0:3];
    logic [7:0] wak [0:3];
    ini = '{8'hE2, 8'hA2, 8'hA0, 8'hC8, 8'hA4, 8'h40, 8'h25, 8'h81, lvl, 8'h2F, 8'hAF};
    slp = '{8'hAC, 8'h00, 8'hAE, 8'hA5};
    wak = '{8'hA4, 8'hAD, 8'h00, 8'hAF};
    case (op)
      0: return ini[i];
      1: return slp[i];
      2: return wak[i];
      default: return (i == 0) ? 8'h81 : lvl;
    endcase
  endfunction

  task automatic fire(bit i, bit s, bit w, bit c, logic [7:0] val);
    @(negedge clk);
    req_init = i; req_sleep = s; req_wake = w; req_contrast = c; contrast_in = val;
    @(negedge clk);
    req_init = 0; req_sleep = 0; req_wake = 0; req_contrast = 0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    check({req, " done seen"}, done, 1);
    check({req, " busy low with done"}, busy, 0);
    @(negedge clk);
    check({req, " done one cycle"}, done, 0);
  endtask

  task automatic compare(string req, int op, logic [7:0] lvl);
    int bad = 0;
    check({req, " byte count"}, cap_n, exp_len(op));
    for (int i = 0; i < exp_len(op) && i < cap_n; i++)
      if (cap[i] !== exp_byte(op, i, lvl)) begin
        bad++;
        check({req, " byte"}, cap[i], exp_byte(op, i, lvl));
      end
    if (bad == 0) check({req, " sequence"}, 1, 1);
  endtask

  task automatic t_reset;
    check("R1 busy after reset", busy, 0);
    check("R1 valid after reset", out_valid, 0);
    check("R1 done after reset", done, 0);
  endtask

  task automatic t_init_default;
    cap_n = 0;
    fire(1, 0, 0, 0, 8'd0);
    wait_done("R4");
    compare("R4 init default 33", 0, 8'h21);
  endtask

  task automatic t_contrast(logic [7:0] v, logic [7:0] exp_lvl);
    cap_n = 0;
    fire(0, 0, 0, 1, v);
    wait_done("R5");
    compare("R5 contrast", 3, exp_lvl);
  endtask

  task automatic t_init_stored;
    t_contrast(8'd50, 8'd50);
    cap_n = 0;
    fire(1, 0, 0, 0, 8'd7);
    wait_done("R6");
    compare("R6 init uses stored level", 0, 8'd50);
  endtask

  task automatic t_sleep_hold;
    cap_n = 0;
    out_ready = 1'b0;
    fire(0, 1, 0, 0, 8'd0);
    check("R3 valid while stalled", out_valid, 1);
    check("R3 first byte", out_byte, 8'hAC);
    fire(0, 0, 1, 0, 8'd0);
    repeat (2) @(negedge clk);
    check("R3 still valid", out_valid, 1);
    check("R3 byte held", out_byte, 8'hAC);
    check("R3 nothing taken", cap_n, 0);
    out_ready = 1'b1;
    wait_done("R7");
    compare("R7 sleep", 1, 8'h00);
    compare("R9 wake dropped while busy", 1, 8'h00);
    repeat (3) @(negedge clk);
    check("R9 idle after dropped request", busy, 0);
  endtask

  task automatic t_wake;
    cap_n = 0;
    fire(0, 0, 1, 0, 8'd0);
    wait_done("R8");
    compare("R8 wake", 2, 8'h00);
  endtask

  task automatic t_priority;
    cap_n = 0;
    fire(1, 1, 1, 1, 8'd5);
    wait_done("R10");
    compare("R10 init wins", 0, 8'h3F);
    cap_n = 0;
    fire(0, 1, 1, 1, 8'd5);
    wait_done("R10");
    compare("R10 sleep wins", 1, 8'h00);
    cap_n = 0;
    fire(0, 0, 1, 1, 8'd5);
    wait_done("R10");
    compare("R10 wake wins", 2, 8'h00);
    cap_n = 0;
    fire(1, 0, 0, 0, 8'd0);
    wait_done("R10");
    compare("R10 losing contrast not stored", 0, 8'h3F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_init_default;
    t_contrast(8'd20, 8'd20);
    t_contrast(8'd63, 8'd63);
    t_contrast(8'd64, 8'd63);
    t_init_stored;
    t_contrast(8'd200, 8'd63);
    t_sleep_hold;
    t_wake;
    t_priority;
    check("R2 command flag low on all bytes", dc_bad, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule